// File: doc/BRIEF.md
# Block Zeroing Engine

This engine clears one naturally aligned block of memory on request. The requester gives a 64-bit byte address that may fall anywhere inside the target block, a size code that selects the block length, and the attributes of the memory region: whether it is device memory, whether that device memory tolerates unaligned accesses, whether writes are permitted, and whether it is cacheable. The engine rounds the address down to the block boundary and clears every byte of the block through a word-wide write port with a ready handshake.

Before any write goes out, the engine classifies the region. A device region that cannot take unaligned accesses produces an alignment fault. A region that forbids writes produces a permission fault. In either case nothing is written, and completion is signalled with a fault flag and a code. The syndrome output that marks a cache-maintenance origin is always reported clear, because the operation is reported as an ordinary store.

Top module: `zero_block_engine`

## Requirements
- R1: The block length in bytes is 4 shifted left by the size code. Codes above 9 are treated as 9, so blocks range from 4 to 2048 bytes.
- R2: The written range starts at the request address rounded down to a multiple of the block length. Any offset inside the same block produces the same writes.
- R3: Each accepted write clears one 8-byte word. Words go out in ascending address order starting at the block base rounded down to 8 bytes, with all-zero data. While wr_ready is low, the pending write keeps wr_en high and keeps the same address.
- R4: A 4-byte block is cleared by a single write whose byte strobe is 0x0F when address bit 2 of the block base is 0, and 0xF0 when it is 1. Larger blocks use strobe 0xFF on every write.
- R5: A device region that does not tolerate unaligned accesses ends the request with no writes. done and fault_valid are raised together with fault_code 01, in the second cycle after the start is accepted.
- R6: A region without write permission, and without an alignment fault, ends with no writes and fault_code 10. The alignment check takes priority over the permission check.
- R7: The cacheable attribute has no effect. A writable region that is not a faulting device region is cleared in full either way.
- R8: synd_cm is always 0.
- R9: done is high for exactly one cycle, the cycle after the last write is accepted. fault_valid is low on success. fault_code reads 00 whenever fault_valid is low.
- R10: A start pulse that arrives while busy is ignored. The request in flight completes unchanged and no second request follows.
- R11: The cycle after a start is accepted is a check cycle. busy is high, wr_en is low, and the first write is presented in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| req_addr | input | 64 | Any byte address inside the target block |
| blk_code | input | 4 | Block size code: length is 4 shifted left by this code |
| attr_device | input | 1 | Region is device memory |
| attr_unaligned_ok | input | 1 | Device region tolerates unaligned accesses |
| attr_writable | input | 1 | Write permission granted |
| attr_cacheable | input | 1 | Cacheability attribute, ignored |
| busy | output | 1 | Request in progress |
| wr_en | output | 1 | Write request valid |
| wr_addr | output | 64 | 8-byte-aligned write address |
| wr_strb | output | 8 | Byte lane enables |
| wr_data | output | 64 | Write data, always zero |
| wr_ready | input | 1 | Memory accepts the current write |
| done | output | 1 | One-cycle completion pulse |
| fault_valid | output | 1 | Completion carries a fault |
| fault_code | output | 2 | 01 alignment, 10 permission, 00 none |
| synd_cm | output | 1 | Cache-maintenance syndrome bit, held 0 |

## Verification
Several properties are checked on every cycle. A stalled write holds its address. Every write lies inside the aligned block. done lasts a single cycle, and a fault never arrives without done. No write is presented in the check cycle, and a faulting completion is never preceded by a write. A non-faulting region reaches the write phase whatever its cacheability. Only the bench scenarios can show the rest: the exact address sequence and word count for each size code and offset, the sub-word strobe choice, the clamping of oversized codes, the fault priority, and that a start arriving mid-request leaves that request intact.

// File: rtl/zbe_pkg.sv
package zbe_pkg;

   typedef enum logic [1:0] {
      FLT_NONE  = 2'b00,
      FLT_ALIGN = 2'b01,
      FLT_PERM  = 2'b10
   } fault_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_CHECK,
      ST_WRITE
   } state_e;

   typedef struct packed {
      logic device;
      logic unaligned_ok;
      logic writable;
   } region_t;

endpackage

// File: rtl/zbe_align.sv
module zbe_align #(
   parameter int ADDR_W  = 64,
   parameter int CODE_W  = 4,
   parameter int UNIT_LG = 2,
   parameter int WORD_LG = 3,
   parameter int IDX_W   = 8
) (
   input  logic [CODE_W-1:0]       code,
   input  logic [ADDR_W-1:0]       addr,
   output logic [ADDR_W-1:0]       blk_mask,
   output logic [ADDR_W-1:0]       blk_base,
   output logic [ADDR_W-1:0]       word_base,
   output logic [IDX_W-1:0]        last_idx,
   output logic [(1<<WORD_LG)-1:0] strb
);
   localparam int LANES = 1 << WORD_LG;

   logic [7:0]     blk_lg;
   logic [IDX_W:0] span;

   assign blk_lg    = 8'(code) + 8'(UNIT_LG);
   assign blk_mask  = {ADDR_W{1'b1}} << blk_lg;
   assign blk_base  = addr & blk_mask;
   assign word_base = {blk_base[ADDR_W-1:WORD_LG], {WORD_LG{1'b0}}};
   assign span      = (IDX_W+1)'(1) << (blk_lg - 8'(WORD_LG));

   always_comb begin
      if (blk_lg > 8'(WORD_LG)) last_idx = span[IDX_W-1:0] - IDX_W'(1);
      else                      last_idx = '0;
   end

   generate
      if (UNIT_LG >= WORD_LG) begin : g_full_lanes
         assign strb = {LANES{1'b1}};
      end else begin : g_sub_lanes
         for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
            assign strb[ln] = ((word_base | ADDR_W'(ln)) & blk_mask) == blk_base;
         end
      end
   endgenerate

endmodule

// File: rtl/zbe_check.sv
module zbe_check
   import zbe_pkg::*;
(
   input  region_t region,
   output fault_e  fault
);
   always_comb begin
      if (region.device && !region.unaligned_ok) fault = FLT_ALIGN;
      else if (!region.writable)                  fault = FLT_PERM;
      else                                        fault = FLT_NONE;
   end
endmodule

// File: rtl/zbe_seq.sv
module zbe_seq
   import zbe_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  fault_e           fault_kind,
   input  logic [IDX_W-1:0] last_idx,
   input  logic             wr_ready,
   output logic             accept,
   output logic             busy,
   output logic             wr_en,
   output logic [IDX_W-1:0] idx,
   output logic             done,
   output logic             fault_valid,
   output fault_e           fault_code
);
   state_e           state_q;
   logic [IDX_W-1:0] idx_q;
   logic             done_q, fv_q;
   fault_e           fc_q;

   assign accept      = start && (state_q == ST_IDLE);
   assign busy        = (state_q != ST_IDLE);
   assign wr_en       = (state_q == ST_WRITE);
   assign idx         = idx_q;
   assign done        = done_q;
   assign fault_valid = fv_q;
   assign fault_code  = fc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         done_q  <= 1'b0;
         fv_q    <= 1'b0;
         fc_q    <= FLT_NONE;
      end else begin
         done_q <= 1'b0;
         fv_q   <= 1'b0;
         fc_q   <= FLT_NONE;
         unique case (state_q)
            ST_IDLE: if (start) state_q <= ST_CHECK;
            ST_CHECK: begin
               idx_q <= '0;
               if (fault_kind != FLT_NONE) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
                  fv_q    <= 1'b1;
                  fc_q    <= fault_kind;
               end else begin
                  state_q <= ST_WRITE;
               end
            end
            ST_WRITE: if (wr_ready) begin
               if (idx_q == last_idx) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  idx_q <= idx_q + IDX_W'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9
   fault_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> done);
   // R9
   clean_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_valid |-> fault_code == FLT_NONE);
   // R5
   fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> (fault_code == FLT_ALIGN || fault_code == FLT_PERM));
   // R11
   no_early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (busy && !wr_en));
   // R5
   fault_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> !$past(wr_en));

endmodule

// File: rtl/zero_block_engine.sv
module zero_block_engine
   import zbe_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int WORD_BYTES = 8,
   parameter int UNIT_BYTES = 4,
   parameter int MAX_CODE   = 9,
   parameter int CODE_W     = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [CODE_W-1:0]       blk_code,
   input  logic                    attr_device,
   input  logic                    attr_unaligned_ok,
   input  logic                    attr_writable,
   input  logic                    attr_cacheable,
   output logic                    busy,
   output logic                    wr_en,
   output logic [ADDR_W-1:0]       wr_addr,
   output logic [WORD_BYTES-1:0]   wr_strb,
   output logic [8*WORD_BYTES-1:0] wr_data,
   input  logic                    wr_ready,
   output logic                    done,
   output logic                    fault_valid,
   output logic [1:0]              fault_code,
   output logic                    synd_cm
);
   localparam int UNIT_LG = $clog2(UNIT_BYTES);
   localparam int WORD_LG = $clog2(WORD_BYTES);
   localparam int IDX_W   = MAX_CODE + UNIT_LG - WORD_LG;

   initial begin
      assert ((1 << UNIT_LG) == UNIT_BYTES && (1 << WORD_LG) == WORD_BYTES)
         else $fatal(1, "unit and word sizes must be powers of two");
      assert (UNIT_BYTES <= WORD_BYTES)
         else $fatal(1, "unit must not exceed word");
      assert (IDX_W >= 1)
         else $fatal(1, "largest block must span more than one word");
      assert (MAX_CODE < (1 << CODE_W))
         else $fatal(1, "code width too small");
   end

   logic [CODE_W-1:0] code_eff, code_q;
   logic [ADDR_W-1:0] addr_q;
   region_t           region_q;
   logic              accept;
   fault_e            fault_kind, fault_out;
   logic [ADDR_W-1:0] blk_mask, blk_base, word_base;
   logic [IDX_W-1:0]  last_idx, idx;

   assign code_eff = (blk_code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : blk_code;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q   <= '0;
         addr_q   <= '0;
         region_q <= '0;
      end else if (accept) begin
         code_q   <= code_eff;
         addr_q   <= req_addr;
         region_q <= '{device: attr_device, unaligned_ok: attr_unaligned_ok,
                       writable: attr_writable};
      end
   end

   zbe_align #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .UNIT_LG(UNIT_LG),
               .WORD_LG(WORD_LG), .IDX_W(IDX_W)) u_align (
      .code(code_q), .addr(addr_q), .blk_mask(blk_mask), .blk_base(blk_base),
      .word_base(word_base), .last_idx(last_idx), .strb(wr_strb));

   zbe_check u_check (.region(region_q), .fault(fault_kind));

   zbe_seq #(.IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .fault_kind(fault_kind),
      .last_idx(last_idx), .wr_ready(wr_ready), .accept(accept), .busy(busy),
      .wr_en(wr_en), .idx(idx), .done(done), .fault_valid(fault_valid),
      .fault_code(fault_out));

   assign wr_addr    = word_base + (ADDR_W'(idx) << WORD_LG);
   assign wr_data    = '0;
   assign fault_code = fault_out;
   assign synd_cm    = 1'b0;

   // R3
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_ready) |=> (wr_en && $stable(wr_addr)));
   // R2
   in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_addr[WORD_LG-1:0] == '0 &&
                 (wr_addr & blk_mask) == (word_base & blk_mask)));
   // R7
   cacheable_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && attr_cacheable && attr_writable &&
       !(attr_device && !attr_unaligned_ok)) |=> ##1 wr_en);
   // R7
   uncached_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !attr_cacheable && attr_writable &&
       !(attr_device && !attr_unaligned_ok)) |=> ##1 wr_en);

endmodule

// File: tb/zero_block_engine_test.sv
module zero_block_engine_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [63:0] req_addr = '0;
   logic [3:0]  blk_code = '0;
   logic        attr_device = 1'b0, attr_unaligned_ok = 1'b0;
   logic        attr_writable = 1'b1, attr_cacheable = 1'b0;
   logic        busy, wr_en, wr_ready = 1'b1, done, fault_valid, synd_cm;
   logic [63:0] wr_addr, wr_data;
   logic [7:0]  wr_strb;
   logic [1:0]  fault_code;

   int vectors = 0;
   int fails   = 0;

   always #4 clk = ~clk;

   zero_block_engine uut (
      .clk(clk), .rst_n(rst_n), .start(start), .req_addr(req_addr),
      .blk_code(blk_code), .attr_device(attr_device),
      .attr_unaligned_ok(attr_unaligned_ok), .attr_writable(attr_writable),
      .attr_cacheable(attr_cacheable), .busy(busy), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_strb(wr_strb), .wr_data(wr_data),
      .wr_ready(wr_ready), .done(done), .fault_valid(fault_valid),
      .fault_code(fault_code), .synd_cm(synd_cm));

   task automatic chk(input bit ok, input string tag,
                      input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic bit ready_at(input int pat, input int cyc);
      case (pat)
         1:       return (cyc % 2) == 0;
         2:       return (cyc % 3) == 2;
         default: return 1'b1;
      endcase
   endfunction

   task automatic run(input logic [63:0] addr, input int code, input bit dev,
                      input bit uok, input bit wrt, input bit cach,
                      input int pat, input bit poke);
      int          eff, words, n, cyc, last;
      int          ef;
      bit          seen;
      logic [63:0] bytes, base, wbase;
      logic [7:0]  estrb;
      eff   = (code > 9) ? 9 : code;
      bytes = 64'd4 << eff;
      base  = addr & ~(bytes - 64'd1);
      wbase = base & ~64'd7;
      words = (eff == 0) ? 1 : int'(bytes / 64'd8);
      estrb = (eff == 0) ? (base[2] ? 8'hF0 : 8'h0F) : 8'hFF;
      ef    = (dev && !uok) ? 1 : (!wrt ? 2 : 0);

      @(negedge clk);
      req_addr = addr; blk_code = 4'(code); attr_device = dev;
      attr_unaligned_ok = uok; attr_writable = wrt; attr_cacheable = cach;
      wr_ready = 1'b1; start = 1'b1;
      @(negedge clk);
      start = poke;
      if (poke) begin
         req_addr = ~addr; blk_code = 4'd0; attr_device = 1'b1;
         attr_unaligned_ok = 1'b0; attr_writable = 1'b0;
      end
      // R11 check cycle: busy, nothing written yet
      chk(busy && !wr_en, "R11 check cycle", {62'd0, busy, wr_en}, 64'h2);

      n = 0; cyc = 0; last = -10; seen = 0;
      while (!seen && cyc < 3000) begin
         @(negedge clk);
         if (done) seen = 1;
         else begin
            if (cyc == 3) start = 1'b0;
            wr_ready = ready_at(pat, cyc);
            if (wr_en && wr_ready) begin
               // R2 R3 ascending addresses from the aligned base
               chk(wr_addr == wbase + 64'(n) * 64'd8, "R2/R3 address",
                   wr_addr, wbase + 64'(n) * 64'd8);
               // R4 lane enables
               chk(wr_strb == estrb, "R4 strobe", 64'(wr_strb), 64'(estrb));
               // R3 zero data
               chk(wr_data == 64'd0, "R3 data", wr_data, 64'd0);
               n++;
               last = cyc;
            end
            cyc++;
         end
      end
      start = 1'b0; wr_ready = 1'b1;
      chk(seen, "R9 done seen", 64'(seen), 64'd1);
      if (ef != 0) begin
         // R5 R6 fault reported in the second cycle, no writes
         chk(cyc == 0, "R5/R6 fault timing", 64'(cyc), 64'd0);
         chk(n == 0, "R5/R6 no writes", 64'(n), 64'd0);
         chk(fault_valid == 1'b1, "R5/R6 fault_valid", 64'(fault_valid), 64'd1);
         chk(fault_code == 2'(ef), "R5/R6 fault_code", 64'(fault_code), 64'(ef));
      end else begin
         // R1 R7 full block written regardless of cacheability
         chk(n == words, "R1/R7 word count", 64'(n), 64'(words));
         // R9 done the cycle after the last acceptance
         chk(cyc == last + 1, "R9 done timing", 64'(cyc), 64'(last + 1));
         chk(!fault_valid && fault_code == 2'b00, "R9 success flags",
             {61'd0, fault_valid, fault_code}, 64'd0);
      end
      // R8 syndrome bit clear
      chk(synd_cm == 1'b0, "R8 synd_cm", 64'(synd_cm), 64'd0);
      chk(!busy, "R9 idle at done", 64'(busy), 64'd0);
      @(negedge clk);
      // R9 one-cycle pulse; R10 no second request from the ignored start
      chk(!done && !busy, "R9/R10 after done", {62'd0, done, busy}, 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R3 R9 reset state
      chk(!busy && !wr_en && !done && !fault_valid && fault_code == 2'b00,
          "R9 reset state", {59'd0, busy, wr_en, done, fault_valid, |fault_code}, 64'd0);
      chk(synd_cm == 1'b0, "R8 reset synd_cm", 64'(synd_cm), 64'd0);
      rst_n = 1'b1;

      for (int code = 0; code < 12; code++) begin
         for (int osel = 0; osel < 4; osel++) begin
            int          eb;
            logic [63:0] hi, off;
            eb  = (code > 9) ? 9 : code;
            hi  = 64'h9E37_79B9_0000_0000 + (64'(code) << 16);
            case (osel)
               0: off = 64'd0;
               1: off = 64'd4 % (64'd4 << eb);
               2: off = ((64'd4 << eb) / 2 + 64'd3) % (64'd4 << eb);
               default: off = (64'd4 << eb) - 64'd1;
            endcase
            // R1 R2 R4 R7 R10 sweep over size codes and offsets
            run(hi + off + 64'h1000 * 64'(osel), code, 1'b0, osel[1], 1'b1,
                osel[0], (code + osel) % 3, (code >= 6 && osel == 1));
         end
      end

      // R5 R6 R7 every attribute combination, two sizes
      for (int combo = 0; combo < 16; combo++) begin
         run(64'h0000_4000_0000_1234, (combo < 8) ? 3 : 0, combo[2], combo[1],
             combo[0], combo[3], combo % 3, 1'b0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule